// File: doc/BRIEF.md
# Pixel Line Statistics Engine

This block sits behind the digitizer of one colour channel of a linear image sensor. Each line arrives as a stream of samples that carry a valid qualifier and are framed by start-of-line and end-of-line markers. In line mode the block sums the valid samples and tracks their smallest and largest values. At line end it divides the sum by the fixed pixel count with a sequential divider. It then reports the floor mean and the larger of the two deviations from that mean (upward to the maximum, downward to the minimum). That deviation is the dark-signal or response non-uniformity figure. The percentage scaling that turns it into a response figure is left to software.

In noise mode the block captures one chosen pixel position from every line. It accumulates that value and its square over a fixed number of lines, then divides `N·Σx² − (Σx)²` by `N²` to give the temporal variance of that pixel. Any square root is left to software. A line whose valid-sample count is wrong is rejected with a one-cycle error pulse and leaves every result untouched.

Top module: `pixel_line_stats`

## Requirements
- R1: After reset `done_o`, `err_o`, `mean_o`, `maxdev_o` and `var_o` are all zero.
- R2: In line mode (`mode_i` = 0), `mean_o` equals the floor of the sum of the LINE_PIX samples that had `valid_i` high, divided by LINE_PIX. Cycles with `valid_i` low are ignored whatever `data_i` carries.
- R3: Valid samples that arrive after an end-of-line and before the next start-of-line belong to no line and have no effect on any result.
- R4: `maxdev_o` equals the larger of (line maximum − `mean_o`) and (`mean_o` − line minimum), with both extremes taken over the same samples as R2.
- R5: A line ending with a valid count other than LINE_PIX, whether short or long, gives a one-cycle `err_o` pulse in the second cycle after the end-of-line cycle. It gives no `done_o`, and all results keep their values.
- R6: For a good line in line mode, `done_o` is a one-cycle pulse. It is high in the cycle that follows DIV_W+2 rising edges counted from the edge that samples end-of-line. DIV_W is the larger of DATA_W+clog2(LINE_PIX+1) and 2·DATA_W+2·clog2(NOISE_LINES+1). `mean_o` and `maxdev_o` change only together with `done_o`.
- R7: In noise mode (`mode_i` = 1), the sample at 0-based valid index `pix_sel_i` of each good line is accumulated. After NOISE_LINES good lines, `var_o` = floor((N·Σx² − (Σx)²)/N²) with N = NOISE_LINES, and `done_o` pulses DIV_W+3 edges after the last end-of-line edge. Earlier lines give no `done_o`, and `mean_o` is not changed.
- R8: In noise mode a line rejected under R5 does not count toward the NOISE_LINES lines and does not enter the sums.
- R9: An end-of-line that arrives while a division is still running gives an `err_o` pulse, and that line is ignored. The running division still completes with its own result.
- R10: A sample with valid high on the same cycle as start-of-line is the first sample of the line. A sample with valid high on the same cycle as end-of-line is its last sample. A new start-of-line in the middle of a line discards what was gathered so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 = line statistics, 1 = single-pixel noise |
| pix_sel_i | input | clog2(LINE_PIX+1) | Valid-sample index captured in noise mode |
| valid_i | input | 1 | Sample qualifier |
| sol_i | input | 1 | Start-of-line marker |
| eol_i | input | 1 | End-of-line marker |
| data_i | input | DATA_W | Pixel value |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | One-cycle rejected-line strobe |
| mean_o | output | DATA_W | Line mean |
| maxdev_o | output | DATA_W | Largest absolute deviation from the mean |
| var_o | output | 2·DATA_W | Temporal variance of the chosen pixel |

## Verification
Latencies are counted in rising edges from the edge that samples end-of-line.
- An error is due after one edge.
- A line-mode result is due after DIV_W+2 edges.
- A noise-mode result is due after DIV_W+3 edges, because one extra cycle forms the numerator.

The bench derives DIV_W from the parameters itself. It counts edges after each end-of-line and samples on the falling edge. It checks that each strobe arrives in exactly the due cycle, and that no other strobe appears in the window. The result ports are read only after the strobe, and are compared with values recomputed from the stimulus.

// File: rtl/lstat_pkg.sv
package lstat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PREP,
    ST_DIV
  } lstat_state_e;

  function automatic int lstat_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lstat_line_acc.sv
module lstat_line_acc #(
  parameter int DATA_W   = 16,
  parameter int LINE_PIX = 10600,
  localparam int CNT_W   = $clog2(LINE_PIX + 1),
  localparam int SUM_W   = DATA_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              sol_i,
  input  logic              eol_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  sel_i,
  output logic              end_o,
  output logic              ok_o,
  output logic [SUM_W-1:0]  sum_o,
  output logic [DATA_W-1:0] min_o,
  output logic [DATA_W-1:0] max_o,
  output logic [DATA_W-1:0] pick_o,
  output logic              picked_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(LINE_PIX);

  logic              in_line_q, in_line_n;
  logic              end_q, end_n;
  logic [CNT_W-1:0]  cnt_q, cnt_b, cnt_n;
  logic              ovf_q, ovf_b, ovf_n;
  logic [SUM_W-1:0]  sum_q, sum_b, sum_n;
  logic [DATA_W-1:0] min_q, min_b, min_n;
  logic [DATA_W-1:0] max_q, max_b, max_n;
  logic [DATA_W-1:0] pick_q, pick_n;
  logic              picked_q, picked_b, picked_n;
  logic              take, upd;

  // a start marker rebases the line state before the same-cycle sample is added
  always_comb begin
    take     = valid_i & (sol_i | in_line_q);
    upd      = sol_i | take;
    cnt_b    = sol_i ? '0 : cnt_q;
    ovf_b    = sol_i ? 1'b0 : ovf_q;
    sum_b    = sol_i ? '0 : sum_q;
    min_b    = sol_i ? '1 : min_q;
    max_b    = sol_i ? '0 : max_q;
    picked_b = sol_i ? 1'b0 : picked_q;
    cnt_n    = cnt_b;
    ovf_n    = ovf_b;
    sum_n    = sum_b;
    min_n    = min_b;
    max_n    = max_b;
    pick_n   = pick_q;
    picked_n = picked_b;
    if (take) begin
      if (cnt_b == FULL) ovf_n = 1'b1;
      else               cnt_n = cnt_b + 1'b1;
      sum_n = sum_b + SUM_W'(data_i);
      if (data_i < min_b) min_n = data_i;
      if (data_i > max_b) max_n = data_i;
      if (!picked_b && cnt_b == sel_i) begin
        pick_n   = data_i;
        picked_n = 1'b1;
      end
    end
    end_n     = eol_i & (sol_i | in_line_q);
    in_line_n = eol_i ? 1'b0 : (sol_i | in_line_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_line_q <= 1'b0;
      end_q     <= 1'b0;
      cnt_q     <= '0;
      ovf_q     <= 1'b0;
      sum_q     <= '0;
      min_q     <= '1;
      max_q     <= '0;
      pick_q    <= '0;
      picked_q  <= 1'b0;
    end else begin
      in_line_q <= in_line_n;
      end_q     <= end_n;
      if (upd) begin
        cnt_q    <= cnt_n;
        ovf_q    <= ovf_n;
        sum_q    <= sum_n;
        min_q    <= min_n;
        max_q    <= max_n;
        pick_q   <= pick_n;
        picked_q <= picked_n;
      end
    end
  end

  assign end_o    = end_q;
  assign ok_o     = (cnt_q == FULL) & ~ovf_q;
  assign sum_o    = sum_q;
  assign min_o    = min_q;
  assign max_o    = max_q;
  assign pick_o   = pick_q;
  assign picked_o = picked_q;
endmodule

// File: rtl/lstat_noise_acc.sv
module lstat_noise_acc #(
  parameter int DATA_W      = 16,
  parameter int NOISE_LINES = 100,
  localparam int NL_W       = $clog2(NOISE_LINES + 1),
  localparam int SX_W       = DATA_W + NL_W,
  localparam int SXX_W      = 2 * DATA_W + NL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [DATA_W-1:0] x_i,
  output logic [SX_W-1:0]   sx_o,
  output logic [SXX_W-1:0]  sxx_o,
  output logic              last_o
);
  logic [SX_W-1:0]  sx_q, sx_n;
  logic [SXX_W-1:0] sxx_q, sxx_n;
  logic [NL_W-1:0]  nl_q, nl_n;
  logic             en;

  always_comb begin
    en    = clr_i | add_i;
    sx_n  = sx_q + SX_W'(x_i);
    sxx_n = sxx_q + SXX_W'(x_i) * SXX_W'(x_i);
    nl_n  = nl_q + 1'b1;
    if (clr_i) begin
      sx_n  = '0;
      sxx_n = '0;
      nl_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sx_q  <= '0;
      sxx_q <= '0;
      nl_q  <= '0;
    end else if (en) begin
      sx_q  <= sx_n;
      sxx_q <= sxx_n;
      nl_q  <= nl_n;
    end
  end

  assign sx_o   = sx_q;
  assign sxx_o  = sxx_q;
  assign last_o = (nl_q == NL_W'(NOISE_LINES - 1));
endmodule

// File: rtl/lstat_div.sv
module lstat_div #(
  parameter int W     = 46,
  parameter int OUT_W = 32,
  localparam int CW   = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [W-1:0]     dvd_i,
  input  logic [W-1:0]     dvs_i,
  output logic             done_o,
  output logic [OUT_W-1:0] quo_o
);
  logic [W-1:0]  rem_q, rem_n, quo_q, quo_n, dvs_q, dvs_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          busy_q, busy_n, done_q, done_n;
  logic [W:0]    trial;
  logic          en;

  // restoring division, one quotient bit per cycle
  always_comb begin
    trial  = {rem_q, quo_q[W-1]};
    rem_n  = rem_q;
    quo_n  = quo_q;
    dvs_n  = dvs_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    done_n = 1'b0;
    en     = start_i | busy_q;
    if (start_i) begin
      rem_n  = '0;
      quo_n  = dvd_i;
      dvs_n  = dvs_i;
      cnt_n  = CW'(W);
      busy_n = 1'b1;
    end else if (busy_q) begin
      if (trial >= {1'b0, dvs_q}) begin
        rem_n = W'(trial - {1'b0, dvs_q});
        quo_n = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_n = trial[W-1:0];
        quo_n = {quo_q[W-2:0], 1'b0};
      end
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_n;
      if (en) begin
        rem_q  <= rem_n;
        quo_q  <= quo_n;
        dvs_q  <= dvs_n;
        cnt_q  <= cnt_n;
        busy_q <= busy_n;
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q[OUT_W-1:0];
endmodule

// File: rtl/pixel_line_stats.sv
module pixel_line_stats
  import lstat_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int LINE_PIX    = 10600,
  parameter int NOISE_LINES = 100,
  localparam int CNT_W      = $clog2(LINE_PIX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_i,
  input  logic [CNT_W-1:0]    pix_sel_i,
  input  logic                valid_i,
  input  logic                sol_i,
  input  logic                eol_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic                done_o,
  output logic                err_o,
  output logic [DATA_W-1:0]   mean_o,
  output logic [DATA_W-1:0]   maxdev_o,
  output logic [2*DATA_W-1:0] var_o
);
  localparam int NL_W  = $clog2(NOISE_LINES + 1);
  localparam int SUM_W = DATA_W + CNT_W;
  localparam int SX_W  = DATA_W + NL_W;
  localparam int SXX_W = 2 * DATA_W + NL_W;
  localparam int NUM_W = 2 * DATA_W + 2 * NL_W;
  localparam int DIV_W = lstat_max(SUM_W, NUM_W);
  localparam int RES_W = 2 * DATA_W;

  logic              a_end, a_ok, a_picked;
  logic [SUM_W-1:0]  a_sum;
  logic [DATA_W-1:0] a_min, a_max, a_pick;
  logic [SX_W-1:0]   n_sx;
  logic [SXX_W-1:0]  n_sxx;
  logic              n_last, n_add, n_clr;
  logic              div_start, div_done;
  logic [DIV_W-1:0]  div_dvd, div_dvs, num;
  logic [RES_W-1:0]  quo;

  lstat_state_e      st_q, st_n;
  logic              job_noise_q, job_noise_n;
  logic [DATA_W-1:0] lmin_q, lmax_q;
  logic              cap_ext;
  logic              done_q, done_n, err_q, err_n;
  logic [DATA_W-1:0] mean_q, dev_q, dev_calc, up_dev, dn_dev;
  logic [RES_W-1:0]  var_q;
  logic              good_end, cap_res;

  lstat_line_acc #(.DATA_W(DATA_W), .LINE_PIX(LINE_PIX)) u_acc (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .sol_i(sol_i), .eol_i(eol_i),
    .data_i(data_i), .sel_i(pix_sel_i), .end_o(a_end), .ok_o(a_ok),
    .sum_o(a_sum), .min_o(a_min), .max_o(a_max), .pick_o(a_pick),
    .picked_o(a_picked)
  );

  lstat_noise_acc #(.DATA_W(DATA_W), .NOISE_LINES(NOISE_LINES)) u_noise (
    .clk(clk), .rst_n(rst_n), .clr_i(n_clr), .add_i(n_add), .x_i(a_pick),
    .sx_o(n_sx), .sxx_o(n_sxx), .last_o(n_last)
  );

  lstat_div #(.W(DIV_W), .OUT_W(RES_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start_i(div_start), .dvd_i(div_dvd),
    .dvs_i(div_dvs), .done_o(div_done), .quo_o(quo)
  );

  // N*sum(x^2) - (sum x)^2, never negative by Cauchy-Schwarz
  assign num = DIV_W'(NOISE_LINES) * DIV_W'(n_sxx) - DIV_W'(n_sx) * DIV_W'(n_sx);

  always_comb begin
    good_end    = a_ok & (~mode_i | a_picked);
    st_n        = st_q;
    job_noise_n = job_noise_q;
    div_start   = 1'b0;
    div_dvd     = '0;
    div_dvs     = '0;
    n_add       = 1'b0;
    n_clr       = ~mode_i;
    cap_ext     = 1'b0;
    err_n       = 1'b0;
    done_n      = 1'b0;
    cap_res     = 1'b0;
    if (st_q != ST_IDLE && a_end) err_n = 1'b1;
    case (st_q)
      ST_IDLE: begin
        if (a_end) begin
          if (!good_end) begin
            err_n = 1'b1;
          end else if (!mode_i) begin
            div_start   = 1'b1;
            div_dvd     = DIV_W'(a_sum);
            div_dvs     = DIV_W'(LINE_PIX);
            job_noise_n = 1'b0;
            cap_ext     = 1'b1;
            st_n        = ST_DIV;
          end else begin
            n_add = 1'b1;
            if (n_last) st_n = ST_PREP;
          end
        end
      end
      ST_PREP: begin
        div_start   = 1'b1;
        div_dvd     = num;
        div_dvs     = DIV_W'(NOISE_LINES * NOISE_LINES);
        job_noise_n = 1'b1;
        n_clr       = 1'b1;
        st_n        = ST_DIV;
      end
      ST_DIV: begin
        if (div_done) begin
          cap_res = 1'b1;
          done_n  = 1'b1;
          st_n    = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_comb begin
    up_dev   = lmax_q - quo[DATA_W-1:0];
    dn_dev   = quo[DATA_W-1:0] - lmin_q;
    dev_calc = (up_dev > dn_dev) ? up_dev : dn_dev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      job_noise_q <= 1'b0;
      lmin_q      <= '0;
      lmax_q      <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      mean_q      <= '0;
      dev_q       <= '0;
      var_q       <= '0;
    end else begin
      st_q        <= st_n;
      job_noise_q <= job_noise_n;
      done_q      <= done_n;
      err_q       <= err_n;
      if (cap_ext) begin
        lmin_q <= a_min;
        lmax_q <= a_max;
      end
      if (cap_res && job_noise_q) begin
        var_q <= quo;
      end
      if (cap_res && !job_noise_q) begin
        mean_q <= quo[DATA_W-1:0];
        dev_q  <= dev_calc;
      end
    end
  end

  assign done_o   = done_q;
  assign err_o    = err_q;
  assign mean_o   = mean_q;
  assign maxdev_o = dev_q;
  assign var_o    = var_q;
endmodule

// File: rtl/lstat_checker.sv
module lstat_checker #(
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                done_o,
  input logic [DATA_W-1:0]   mean_o,
  input logic [DATA_W-1:0]   maxdev_o,
  input logic [2*DATA_W-1:0] var_o,
  input logic                job_noise,
  input logic [DATA_W-1:0]   lmin,
  input logic [DATA_W-1:0]   lmax
);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_mean_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mean_o) |-> done_o);

  p_var_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(var_o) |-> (done_o && job_noise));

  p_mean_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !job_noise) |-> (lmin <= mean_o && mean_o <= lmax));

  p_dev_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !job_noise) |-> (maxdev_o <= lmax - lmin));
endmodule

bind pixel_line_stats lstat_checker #(.DATA_W(DATA_W)) u_lstat_chk (
  .clk(clk), .rst_n(rst_n), .done_o(done_o), .mean_o(mean_o),
  .maxdev_o(maxdev_o), .var_o(var_o), .job_noise(job_noise_q),
  .lmin(lmin_q), .lmax(lmax_q)
);

// File: tb/test_pixel_line_stats.sv
module test_pixel_line_stats;
  localparam int DW    = 8;
  localparam int LP    = 8;
  localparam int NL    = 4;
  localparam int CW    = $clog2(LP + 1);
  localparam int NLW   = $clog2(NL + 1);
  localparam int SUMW  = DW + CW;
  localparam int NUMW  = 2 * DW + 2 * NLW;
  localparam int DIVW  = (SUMW > NUMW) ? SUMW : NUMW;
  localparam int LAT_L = DIVW + 2;
  localparam int LAT_N = DIVW + 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            mode = 1'b0;
  logic [CW-1:0]   pix_sel = '0;
  logic            valid = 1'b0, sol = 1'b0, eol = 1'b0;
  logic [DW-1:0]   data = '0;
  logic            done_o, err_o;
  logic [DW-1:0]   mean_o, maxdev_o;
  logic [2*DW-1:0] var_o;

  int n_chk = 0, n_fail = 0;
  int dn_k, er_k, dn_cnt, er_cnt;
  int unsigned seed = 32'h1234_5678;
  logic [DW-1:0] px [0:15];
  longint e_mean, e_dev;

  always #10 clk = ~clk;

  pixel_line_stats #(.DATA_W(DW), .LINE_PIX(LP), .NOISE_LINES(NL)) i_pixel_line_stats (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .pix_sel_i(pix_sel),
    .valid_i(valid), .sol_i(sol), .eol_i(eol), .data_i(data),
    .done_o(done_o), .err_o(err_o), .mean_o(mean_o), .maxdev_o(maxdev_o),
    .var_o(var_o)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[23:16];
  endfunction

  task automatic drive_line(input int n, input bit gaps, input bit with_eol);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 1'b1; data = px[i]; sol = (i == 0); eol = with_eol && (i == n - 1);
      if (gaps && i != n - 1) begin
        @(negedge clk);
        valid = 1'b0; sol = 1'b0; eol = 1'b0; data = 8'hF7;
      end
    end
    @(posedge clk);
  endtask

  task automatic junk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 1'b1; sol = 1'b0; eol = 1'b0; data = 8'hFF;
    end
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic observe(input int cycles);
    dn_cnt = 0; er_cnt = 0; dn_k = -1; er_k = -1;
    @(negedge clk);
    valid = 1'b0; sol = 1'b0; eol = 1'b0;
    for (int k = 1; k <= cycles; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (done_o) begin dn_cnt++; if (dn_k < 0) dn_k = k; end
      if (err_o)  begin er_cnt++; if (er_k < 0) er_k = k; end
    end
  endtask

  task automatic line_expect();
    longint s = 0, mn = 255, mx = 0;
    for (int i = 0; i < LP; i++) begin
      s += px[i];
      if (px[i] < mn) mn = px[i];
      if (px[i] > mx) mx = px[i];
    end
    e_mean = s / LP;
    e_dev  = ((mx - e_mean) > (e_mean - mn)) ? (mx - e_mean) : (e_mean - mn);
  endtask

  task automatic good_line(input bit gaps, input string rq);
    line_expect();
    drive_line(LP, gaps, 1'b1);
    observe(LAT_L + 4);
    chk("R6", "done count", dn_cnt, 1);
    chk("R6", "done latency", dn_k, LAT_L);
    chk("R5", "no err on good line", er_cnt, 0);
    chk(rq, "mean", mean_o, e_mean);
    chk("R4", "max deviation", maxdev_o, e_dev);
  endtask

  task automatic bad_line(input int n, input string what);
    longint m0 = mean_o, d0 = maxdev_o;
    for (int i = 0; i < n; i++) px[i] = rnd();
    drive_line(n, 1'b0, 1'b1);
    observe(LAT_L + 4);
    chk("R5", {what, " err count"}, er_cnt, 1);
    chk("R5", {what, " err cycle"}, er_k, 1);
    chk("R5", {what, " no done"}, dn_cnt, 0);
    chk("R5", {what, " mean kept"}, mean_o, m0);
    chk("R5", {what, " dev kept"}, maxdev_o, d0);
  endtask

  task automatic noise_run(input int run);
    longint sx = 0, sxx = 0, v, m0;
    m0 = mean_o;
    for (int j = 0; j < NL; j++) begin
      for (int i = 0; i < LP; i++) px[i] = rnd();
      case (run)
        0: v = (j == 0) ? 3 : (j == 1) ? 200 : (j == 2) ? 17 : 90;
        1: v = (j % 2 == 0) ? 0 : 255;
        default: v = 42;
      endcase
      px[5] = DW'(v);
      sx += v; sxx += v * v;
      drive_line(LP, j[0], 1'b1);
      if (j < NL - 1) begin
        observe(LAT_N + 4);
        chk("R7", "no result before last line", dn_cnt, 0);
        chk("R7", "no err on noise line", er_cnt, 0);
      end else begin
        observe(LAT_N + 4);
        chk("R7", "noise done count", dn_cnt, 1);
        chk("R7", "noise done latency", dn_k, LAT_N);
        chk("R7", "variance", var_o, (NL * sxx - sx * sx) / (NL * NL));
        chk("R7", "mean untouched in noise mode", mean_o, m0);
      end
      if (j == 1) begin
        for (int i = 0; i < LP - 1; i++) px[i] = 8'd250;
        drive_line(LP - 1, 1'b0, 1'b1);
        observe(LAT_N + 4);
        chk("R8", "rejected noise line err", er_cnt, 1);
        chk("R8", "rejected noise line no done", dn_cnt, 0);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R6 watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    longint am, ad;
    repeat (3) @(negedge clk);
    chk("R1", "done after reset", done_o, 0);
    chk("R1", "err after reset", err_o, 0);
    chk("R1", "mean after reset", mean_o, 0);
    chk("R1", "dev after reset", maxdev_o, 0);
    chk("R1", "var after reset", var_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // line mode sweep
    for (int p = 0; p < 16; p++) begin
      for (int i = 0; i < LP; i++) begin
        case (p)
          0: px[i] = 8'd77;
          1: px[i] = DW'(i);
          2: px[i] = 8'd255;
          3: px[i] = 8'd0;
          4: px[i] = (i == 3) ? 8'd250 : 8'd10;
          5: px[i] = (i == 6) ? 8'd1 : 8'd200;
          default: px[i] = rnd();
        endcase
      end
      if (p >= 8) begin
        junk(3);
        good_line(p[0], "R3");
      end else begin
        good_line(p[0], "R2");
      end
    end

    bad_line(LP - 1, "short");
    bad_line(LP + 1, "long");

    // restart mid-line: R10
    for (int i = 0; i < LP; i++) px[i] = 8'd240;
    drive_line(3, 1'b0, 1'b0);
    for (int i = 0; i < LP; i++) px[i] = DW'(20 + 3 * i);
    good_line(1'b0, "R10");

    // end-of-line while dividing: R9
    for (int i = 0; i < LP; i++) px[i] = rnd();
    line_expect();
    am = e_mean; ad = e_dev;
    drive_line(LP, 1'b0, 1'b1);
    for (int i = 0; i < LP; i++) px[i] = 8'd255;
    drive_line(LP, 1'b0, 1'b1);
    observe(LAT_L + 4);
    chk("R9", "busy err count", er_cnt, 1);
    chk("R9", "busy err cycle", er_k, 1);
    chk("R9", "first line done", dn_cnt, 1);
    chk("R9", "first line mean", mean_o, am);
    chk("R9", "first line dev", maxdev_o, ad);

    // noise mode
    @(negedge clk);
    mode = 1'b1; pix_sel = CW'(5);
    for (int r = 0; r < 3; r++) noise_run(r);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule